// File: doc/BRIEF.md
# Keypad Matrix Scanner with Event Reporting

This block runs a hardware scan of a key matrix of up to 8 rows by 8 columns. It pulls one row low at a time and samples the column lines through a two-stage synchronizer. Each completed pass over all rows is one frame. The block filters the frame pattern against bounce and keeps a debounced bitmap of pressed keys, which software reads as two 32-bit words.

From the debounced bitmap the block derives three kinds of event:

- a key change;
- a hold event, which is either a single long-press notice or a periodic repeat;
- an inactivity timeout.

Events go into a status register. Software clears a status bit by writing 1 to it. The status register has one current slot and one waiting slot. Any further event sets a sticky overflow bit. The interrupt line and the wake request are masked ORs of the three event bits.

Software configures the block through a flat register port. Writes take effect on the clock edge. Reads are combinational on the address.

Register map:

| Address | Contents |
|---|---|
| 0 | control |
| 1 | hold period |
| 2 | idle limit |
| 3 | debounce count |
| 4 | status |
| 5 | enable-set, which reads back the enables |
| 6 | enable-clear |
| 7 | wake mask |
| 8 | low word of the key bitmap |
| 9 | high word of the key bitmap |

Top module: `keypadCtrl`

## Requirements
- R1: After reset, the following are all zero: status, interrupt enables, wake mask, mode bits and the scan-enable bit. `rowDrive` is all ones, and `irq` and `wake` are low. Key-change detection needs no mode bit.
- R2: Control bit 0 enables scanning. While it is set, exactly one row is low at a time. The low row steps 0,1,…,ROWS-1 and then wraps, and each row stays low for TICK_DIV clocks. While the bit is clear, every row is high and the key bitmap reads zero.
- R3: The bitmap updates only after the same complete frame pattern has been seen in debounce+1 consecutive frames. The debounce count is 6 bits at address 3. A shorter glitch leaves the bitmap unchanged. Key (row r, column c) is at bitmap bit r*COLS+c. Address 8 returns bits 31:0 and address 9 returns bits 63:32.
- R4: Each bitmap update raises status bit 0. When control bit 4 (press-only) is set, an update that presses no new key raises no event.
- R5: When control bit 1 (long-press) is set, status bit 1 is raised once after the bitmap has stayed unchanged and non-zero for the hold period in frames. The hold period is 12 bits at address 1, and a value of 0 disables the event.
- R6: When control bit 2 (repeat) is set and control bit 1 is clear, status bit 1 is raised every hold period while keys stay held. When both bits are set, the long-press behaviour applies.
- R7: When control bit 3 (timeout) is set, status bit 2 is raised once when the frames since the last bitmap update reach the idle limit. The idle limit is 16 bits at address 2, and a value of 0 disables the event. Any bitmap update restarts the count.
- R8: Writing 1 to a bit of the status register at address 4 clears that bit. Writing 0 leaves it unchanged.
- R9: An event that arrives while status bits 2:0 are non-zero waits in a single pending slot. It appears in the status register on the same edge that clears the last set bit of 2:0. Events that arrive in the same cycle merge into one event.
- R10: An event that arrives while both the current slot and the pending slot are full sets status bit 3. Bit 3 stays set until it is cleared, and it never drives `irq` or `wake`.
- R11: `irq` is high exactly when a status bit in 2:0 has its enable set. Writing 1s to address 5 sets enables and writing 1s to address 6 clears them. Reading address 5 returns the enables.
- R12: `wake` is high exactly when a status bit in 2:0 is selected by the wake mask at address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 16 | Write data |
| regRdData | output | 32 | Read data for regAddr |
| colSense | input | COLS | Column lines, low when a key on the driven row is pressed |
| rowDrive | output | ROWS | Row lines, one driven low while scanning |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request |

## Verification
The matrix is stimulated with the following patterns:

- single presses;
- two keys in different rows and different words;
- a glitch shorter than the debounce window;
- a release of two keys together;
- a press-release-press burst.

These patterns separate bit placement, filtering and the point at which the queue overflows. The hold tests run long-press, repeat and both together on the same held key, which tells single firing apart from periodic firing. The timeout test releases a key and then presses it again, which shows that the idle count restarts.

// File: rtl/kpdPkg.sv
package kpdPkg;

  typedef struct packed {
    logic        scanEn;
    logic        modeLong;
    logic        modeRepeat;
    logic        modeIdle;
    logic        pressOnly;
    logic [11:0] holdLimit;
    logic [15:0] idleLimit;
    logic [5:0]  debLimit;
  } scanCfgT;

  // bit 0 key change, bit 1 hold, bit 2 idle
  typedef struct packed {
    logic idleEv;
    logic holdEv;
    logic keyEv;
  } eventT;

  localparam logic [3:0] ADDR_CTRL    = 4'd0;
  localparam logic [3:0] ADDR_HOLD    = 4'd1;
  localparam logic [3:0] ADDR_IDLE    = 4'd2;
  localparam logic [3:0] ADDR_DEB     = 4'd3;
  localparam logic [3:0] ADDR_STAT    = 4'd4;
  localparam logic [3:0] ADDR_EN_SET  = 4'd5;
  localparam logic [3:0] ADDR_EN_CLR  = 4'd6;
  localparam logic [3:0] ADDR_WAKE    = 4'd7;
  localparam logic [3:0] ADDR_CODE_LO = 4'd8;
  localparam logic [3:0] ADDR_CODE_HI = 4'd9;

endpackage

// File: rtl/kpdScanPath.sv
module kpdScanPath
  import kpdPkg::*;
#(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int TICK_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  scanCfgT              cfg,
  input  logic [COLS-1:0]      colSense,
  output logic [ROWS-1:0]      rowDrive,
  output logic [ROWS*COLS-1:0] keyMap,
  output eventT                events,
  output logic                 frameEnd
);
  localparam int KEYS = ROWS * COLS;
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int TW   = $clog2(TICK_DIV);

  logic [TW-1:0]   tickCnt;
  logic [RW-1:0]   rowIdx;
  logic [COLS-1:0] colMeta, colSync;
  logic [KEYS-1:0] frameAcc, prevFrame, frameNow;
  logic [5:0]      stableCnt, stableNext;
  logic [11:0]     holdCnt, holdNext, holdInc;
  logic [15:0]     idleCnt, idleNext;
  logic            scanTick, lastRow, mapUpdate, holdFire, idleFire, held;

  // one row low at a time while scanning
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign rowDrive[r] = !(cfg.scanEn && rowIdx == RW'(r));
  end

  assign scanTick = cfg.scanEn && (tickCnt == TW'(TICK_DIV - 1));
  assign lastRow  = (rowIdx == RW'(ROWS - 1));
  assign frameEnd = scanTick && lastRow;
  assign held     = |keyMap;

  always_comb begin
    frameNow = frameAcc;
    for (int r = 0; r < ROWS; r++)
      if (rowIdx == RW'(r)) frameNow[r*COLS +: COLS] = ~colSync;
  end

  always_comb begin
    if (frameNow == prevFrame)
      stableNext = (stableCnt == 6'h3F) ? stableCnt : stableCnt + 6'd1;
    else
      stableNext = '0;
    mapUpdate = (stableNext >= cfg.debLimit) && (frameNow != keyMap);
  end

  always_comb begin
    idleNext = (idleCnt == 16'hFFFF) ? idleCnt : idleCnt + 16'd1;
    idleFire = cfg.modeIdle && (cfg.idleLimit != '0) &&
               (idleNext == cfg.idleLimit) && (idleCnt != cfg.idleLimit);
  end

  always_comb begin
    holdInc  = (holdCnt == 12'hFFF) ? holdCnt : holdCnt + 12'd1;
    holdNext = holdInc;
    holdFire = 1'b0;
    if (!held || cfg.holdLimit == '0) begin
      holdNext = '0;
    end else if (cfg.modeLong) begin
      holdNext = (holdCnt >= cfg.holdLimit) ? holdCnt : holdInc;
      holdFire = (holdCnt < cfg.holdLimit) && (holdInc == cfg.holdLimit);
    end else if (cfg.modeRepeat) begin
      if (holdInc >= cfg.holdLimit) begin
        holdNext = '0;
        holdFire = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cfg.scanEn) begin
      tickCnt   <= '0;
      rowIdx    <= '0;
      colMeta   <= '1;
      colSync   <= '1;
      frameAcc  <= '0;
      prevFrame <= '0;
      stableCnt <= '0;
      keyMap    <= '0;
      holdCnt   <= '0;
      idleCnt   <= '0;
      events    <= '0;
    end else begin
      colMeta <= colSense;
      colSync <= colMeta;
      events  <= '0;
      if (scanTick) begin
        tickCnt  <= '0;
        rowIdx   <= lastRow ? '0 : rowIdx + 1'b1;
        frameAcc <= frameNow;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
      if (frameEnd) begin
        prevFrame <= frameNow;
        stableCnt <= stableNext;
        if (mapUpdate) begin
          keyMap       <= frameNow;
          holdCnt      <= '0;
          idleCnt      <= '0;
          events.keyEv <= !cfg.pressOnly || (|(frameNow & ~keyMap));
        end else begin
          holdCnt       <= holdNext;
          idleCnt       <= idleNext;
          events.holdEv <= holdFire;
          events.idleEv <= idleFire;
        end
      end
    end
  end

endmodule

// File: rtl/kpdEventCtl.sv
module kpdEventCtl
  import kpdPkg::*;
#(
  parameter int KEYS = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            regWrEn,
  input  logic [3:0]      regAddr,
  input  logic [15:0]     regWrData,
  output logic [31:0]     regRdData,
  input  eventT           events,
  input  logic [KEYS-1:0] keyMap,
  output scanCfgT         cfg,
  output logic [3:0]      statusBits,
  output logic            pendValid,
  output logic [2:0]      irqEn,
  output logic            irq,
  output logic            wake
);
  logic [3:0]  modeBits;
  logic [2:0]  wakeEn, pendMask;
  logic [2:0]  slotNext, pendMaskNext, evMask;
  logic        pendNext, missNext;
  logic [3:0]  clrMask;
  logic [63:0] fullCode;

  assign cfg.modeLong   = modeBits[0];
  assign cfg.modeRepeat = modeBits[1];
  assign cfg.modeIdle   = modeBits[2];
  assign cfg.pressOnly  = modeBits[3];
  assign evMask         = events;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.scanEn    <= 1'b0;
      modeBits      <= '0;
      cfg.holdLimit <= '0;
      cfg.idleLimit <= '0;
      cfg.debLimit  <= '0;
      irqEn         <= '0;
      wakeEn        <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_CTRL:   {modeBits, cfg.scanEn} <= regWrData[4:0];
        ADDR_HOLD:   cfg.holdLimit <= regWrData[11:0];
        ADDR_IDLE:   cfg.idleLimit <= regWrData;
        ADDR_DEB:    cfg.debLimit  <= regWrData[5:0];
        ADDR_EN_SET: irqEn  <= irqEn | regWrData[2:0];
        ADDR_EN_CLR: irqEn  <= irqEn & ~regWrData[2:0];
        ADDR_WAKE:   wakeEn <= regWrData[2:0];
        default: ;
      endcase
    end
  end

  // clear, promote the pending slot, then place the new event
  always_comb begin
    clrMask      = (regWrEn && regAddr == ADDR_STAT) ? regWrData[3:0] : 4'd0;
    slotNext     = statusBits[2:0] & ~clrMask[2:0];
    missNext     = statusBits[3] & ~clrMask[3];
    pendNext     = pendValid;
    pendMaskNext = pendMask;
    if (slotNext == '0 && pendNext) begin
      slotNext = pendMask;
      pendNext = 1'b0;
    end
    if (evMask != '0) begin
      if (slotNext == '0) begin
        slotNext = evMask;
      end else if (!pendNext) begin
        pendNext     = 1'b1;
        pendMaskNext = evMask;
      end else begin
        missNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusBits <= '0;
      pendValid  <= 1'b0;
      pendMask   <= '0;
    end else begin
      statusBits <= {missNext, slotNext};
      pendValid  <= pendNext;
      pendMask   <= pendMaskNext;
    end
  end

  assign irq  = |(statusBits[2:0] & irqEn);
  assign wake = |(statusBits[2:0] & wakeEn);

  always_comb begin
    fullCode             = '0;
    fullCode[KEYS-1:0]   = keyMap;
    case (regAddr)
      ADDR_CTRL:    regRdData = {27'd0, modeBits, cfg.scanEn};
      ADDR_HOLD:    regRdData = {20'd0, cfg.holdLimit};
      ADDR_IDLE:    regRdData = {16'd0, cfg.idleLimit};
      ADDR_DEB:     regRdData = {26'd0, cfg.debLimit};
      ADDR_STAT:    regRdData = {28'd0, statusBits};
      ADDR_EN_SET:  regRdData = {29'd0, irqEn};
      ADDR_EN_CLR:  regRdData = {29'd0, irqEn};
      ADDR_WAKE:    regRdData = {29'd0, wakeEn};
      ADDR_CODE_LO: regRdData = fullCode[31:0];
      ADDR_CODE_HI: regRdData = fullCode[63:32];
      default:      regRdData = '0;
    endcase
  end

endmodule

// File: rtl/keypadCtrl.sv
module keypadCtrl
  import kpdPkg::*;
#(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int TICK_DIV = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            regWrEn,
  input  logic [3:0]      regAddr,
  input  logic [15:0]     regWrData,
  output logic [31:0]     regRdData,
  input  logic [COLS-1:0] colSense,
  output logic [ROWS-1:0] rowDrive,
  output logic            irq,
  output logic            wake
);
  localparam int KEYS = ROWS * COLS;

  scanCfgT         cfg;
  eventT           events;
  logic [KEYS-1:0] keyMap;
  logic            frameEnd;
  logic [3:0]      statusBits;
  logic            pendValid;
  logic [2:0]      irqEn;

  kpdScanPath #(.ROWS(ROWS), .COLS(COLS), .TICK_DIV(TICK_DIV)) i_scan (
    .clk(clk), .rst(rst), .cfg(cfg), .colSense(colSense),
    .rowDrive(rowDrive), .keyMap(keyMap), .events(events), .frameEnd(frameEnd)
  );

  kpdEventCtl #(.KEYS(KEYS)) i_evt (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .events(events),
    .keyMap(keyMap), .cfg(cfg), .statusBits(statusBits),
    .pendValid(pendValid), .irqEn(irqEn), .irq(irq), .wake(wake)
  );

endmodule

// File: rtl/kpdCheck.sv
module kpdCheck #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ROWS-1:0]      rowDrive,
  input logic                 irq,
  input logic                 wake,
  input logic [ROWS*COLS-1:0] keyMap,
  input logic                 frameEnd,
  input logic                 scanOn,
  input logic [3:0]           statusBits,
  input logic                 pendValid,
  input logic [2:0]           irqEn,
  input logic                 regWrEn,
  input logic [3:0]           regAddr,
  input logic                 clrMiss
);
  // R2: never more than one row low
  a_r2_one_row_low: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~rowDrive));

  // R3: the bitmap only moves at the end of a frame while scanning
  a_r3_map_on_frame: assert property (@(posedge clk) disable iff (rst)
    (scanOn && !frameEnd) |=> $stable(keyMap));

  // R9: a waiting event never sits behind an empty slot
  a_r9_no_gap: assert property (@(posedge clk) disable iff (rst)
    pendValid |-> (statusBits[2:0] != 3'd0));

  // R10: overflow bit is sticky until cleared
  a_r10_miss_sticky: assert property (@(posedge clk) disable iff (rst)
    (statusBits[3] && !(regWrEn && regAddr == kpdPkg::ADDR_STAT && clrMiss))
      |=> statusBits[3]);

  // R10: overflow alone drives neither request
  a_r10_miss_quiet: assert property (@(posedge clk) disable iff (rst)
    (statusBits[2:0] == 3'd0) |-> (!irq && !wake));

  // R11: no interrupt with all enables off
  a_r11_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
    (irqEn == 3'd0) |-> !irq);
endmodule

bind keypadCtrl kpdCheck #(.ROWS(ROWS), .COLS(COLS)) i_kpdCheck (
  .clk(clk), .rst(rst), .rowDrive(rowDrive), .irq(irq), .wake(wake),
  .keyMap(keyMap), .frameEnd(frameEnd), .scanOn(cfg.scanEn),
  .statusBits(statusBits), .pendValid(pendValid), .irqEn(irqEn),
  .regWrEn(regWrEn), .regAddr(regAddr), .clrMiss(regWrData[3])
);

// File: tb/test_keypadCtrl.sv
`timescale 1ns/1ps
module test_keypadCtrl;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int TDIV = 4;
  localparam int FRAME = ROWS * TDIV;

  logic        clk = 0;
  logic        rst = 1;
  logic        wrEn = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [31:0] rdata;
  logic [COLS-1:0] colSense;
  logic [ROWS-1:0] rowDrive;
  logic        irq, wake;
  logic [63:0] pressed = '0;

  int checks = 0;
  int fails  = 0;

  keypadCtrl #(.ROWS(ROWS), .COLS(COLS), .TICK_DIV(TDIV)) i_keypadCtrl (
    .clk(clk), .rst(rst), .regWrEn(wrEn), .regAddr(addr), .regWrData(wdata),
    .regRdData(rdata), .colSense(colSense), .rowDrive(rowDrive),
    .irq(irq), .wake(wake)
  );

  always #4 clk = ~clk;

  // matrix model: a pressed key pulls its column low when its row is driven
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      colSense[c] = 1'b1;
      for (int r = 0; r < ROWS; r++)
        if (!rowDrive[r] && pressed[r*COLS+c]) colSense[c] = 1'b0;
    end
  end

  // reference model of the event store
  logic [2:0] q[$];
  bit         missed = 0;
  logic [2:0] expEn = 0, expWake = 0;
  bit         modelOn = 0;
  logic [3:0] ms;

  function automatic void push(logic [2:0] m);
    if (q.size() < 2) q.push_back(m); else missed = 1;
  endfunction

  function automatic void modelClear(logic [3:0] c);
    if (c[3]) missed = 0;
    if (q.size() > 0) begin
      q[0] = q[0] & ~c[2:0];
      if (q[0] == 3'd0) void'(q.pop_front());
    end
  endfunction

  function automatic logic [3:0] expStat();
    return {missed, (q.size() > 0) ? q[0] : 3'd0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model (R11, R12)
  always @(negedge clk) begin
    #1;
    if (modelOn && !rst) begin
      ms = expStat();
      chk("R11 irq per clock", 64'(irq), 64'(|(ms[2:0] & expEn)));
      chk("R12 wake per clock", 64'(wake), 64'(|(ms[2:0] & expWake)));
    end
  end

  task automatic regWr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 0;
    case (a)
      4'd4: modelClear(d[3:0]);
      4'd5: expEn = expEn | d[2:0];
      4'd6: expEn = expEn & ~d[2:0];
      4'd7: expWake = d[2:0];
      default: ;
    endcase
  endtask

  task automatic regRd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic waitFrames(input int n);
    repeat (n * FRAME) @(negedge clk);
  endtask

  task automatic keySet(input int idx, input bit v);
    @(negedge clk);
    pressed[idx] = v;
  endtask

  // change a key, let it settle, then book the expected event
  task automatic keyEvent(input int idx, input bit v, input bit expectEv);
    modelOn = 0;
    keySet(idx, v);
    waitFrames(5);
    if (expectEv) push(3'b001);
    modelOn = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 rows idle", 64'(rowDrive), 64'hFF);
    chk("R1 irq low", 64'(irq), 0);
    chk("R1 wake low", 64'(wake), 0);
    regRd(4'd4, v); chk("R1 status", 64'(v), 0);
    regRd(4'd5, v); chk("R1 enables", 64'(v), 0);
    regRd(4'd0, v); chk("R1 control", 64'(v), 0);
    regRd(4'd7, v); chk("R1 wake mask", 64'(v), 0);

    regWr(4'd3, 16'd1);
    regWr(4'd0, 16'h0001);
    modelOn = 1;

    // R2 row order and dwell
    while (rowDrive !== 8'hFE) @(negedge clk);
    for (int k = 1; k < 16; k++) begin
      repeat (TDIV) @(negedge clk);
      chk("R2 row step", 64'(rowDrive), 64'(8'(~(8'd1 << (k % ROWS)))));
    end

    // R3 R4 bitmap placement and key event
    keyEvent(21, 1, 1);
    regRd(4'd4, v); chk("R4 key event", 64'(v), 64'(expStat()));
    regRd(4'd8, v); chk("R3 low word", 64'(v), 64'(32'd1 << 21));
    keyEvent(51, 1, 1);
    regRd(4'd9, v); chk("R3 high word", 64'(v), 64'(32'd1 << 19));
    regRd(4'd4, v); chk("R9 second waits", 64'(v), 64'h1);

    // R11 R12 enables and wake mask
    regWr(4'd5, 16'h1);
    chk("R11 irq on enable", 64'(irq), 1);
    regRd(4'd5, v); chk("R11 enable readback", 64'(v), 1);
    regWr(4'd7, 16'h1);
    chk("R12 wake on mask", 64'(wake), 1);

    // R8 write 0 keeps, R9 promotion on clear
    regWr(4'd4, 16'h0);
    regRd(4'd4, v); chk("R8 zero write keeps", 64'(v), 64'h1);
    regWr(4'd4, 16'h1);
    regRd(4'd4, v); chk("R9 pending promoted", 64'(v), 64'h1);
    chk("R9 irq stays", 64'(irq), 1);
    regWr(4'd4, 16'h1);
    regRd(4'd4, v); chk("R8 cleared", 64'(v), 64'h0);
    chk("R8 irq drops", 64'(irq), 0);

    // R3 glitch shorter than debounce
    regWr(4'd3, 16'd4);
    modelOn = 0;
    keySet(0, 1);
    repeat (FRAME) @(negedge clk);
    keySet(0, 0);
    waitFrames(8);
    modelOn = 1;
    regRd(4'd8, v); chk("R3 glitch ignored map", 64'(v), 64'(32'd1 << 21));
    regRd(4'd4, v); chk("R3 glitch no event", 64'(v), 64'h0);
    regWr(4'd3, 16'd1);

    // R10 third event overflows
    regWr(4'd5, 16'h7);
    regWr(4'd7, 16'h7);
    modelOn = 0;
    @(negedge clk);
    pressed[21] = 0; pressed[51] = 0;
    waitFrames(5);
    push(3'b001);
    modelOn = 1;
    keyEvent(0, 1, 1);
    keyEvent(0, 0, 1);
    regRd(4'd4, v); chk("R10 overflow set", 64'(v), 64'h9);
    regRd(4'd9, v); chk("R3 release clears", 64'(v), 64'h0);
    regWr(4'd4, 16'h1);
    regRd(4'd4, v); chk("R10 overflow kept", 64'(v), 64'h9);
    regWr(4'd4, 16'h1);
    regRd(4'd4, v); chk("R10 overflow only", 64'(v), 64'h8);
    chk("R10 no irq", 64'(irq), 0);
    chk("R10 no wake", 64'(wake), 0);
    regWr(4'd4, 16'h8);
    regRd(4'd4, v); chk("R8 overflow cleared", 64'(v), 64'h0);

    // R4 press-only mode
    regWr(4'd0, 16'h0011);
    keyEvent(9, 1, 1);
    keyEvent(9, 0, 0);
    regRd(4'd4, v); chk("R4 press only", 64'(v), 64'h1);
    regWr(4'd4, 16'h1);

    // R5 long press fires once
    regWr(4'd1, 16'd20);
    regWr(4'd0, 16'h0003);
    keyEvent(9, 1, 1);
    regWr(4'd4, 16'h1);
    modelOn = 0; waitFrames(20); push(3'b010); modelOn = 1;
    regRd(4'd4, v); chk("R5 long press", 64'(v), 64'h2);
    regWr(4'd4, 16'h2);
    modelOn = 0; waitFrames(45); modelOn = 1;
    regRd(4'd4, v); chk("R5 only once", 64'(v), 64'h0);

    // R6 repeat fires periodically
    regWr(4'd0, 16'h0005);
    modelOn = 0; waitFrames(2); push(3'b010); modelOn = 1;
    regRd(4'd4, v); chk("R6 repeat first", 64'(v), 64'h2);
    regWr(4'd4, 16'h2);
    modelOn = 0; waitFrames(22); push(3'b010); modelOn = 1;
    regRd(4'd4, v); chk("R6 repeat again", 64'(v), 64'h2);
    regWr(4'd4, 16'h2);

    // R6 both modes behave as long press
    regWr(4'd0, 16'h0007);
    modelOn = 0; waitFrames(45); push(3'b010); modelOn = 1;
    regRd(4'd4, v); chk("R6 both one event", 64'(v), 64'h2);
    regWr(4'd4, 16'h2);
    regRd(4'd4, v); chk("R6 both no second", 64'(v), 64'h0);

    // R7 timeout once, restart on activity
    regWr(4'd2, 16'd10);
    regWr(4'd0, 16'h0009);
    keyEvent(9, 0, 1);
    regWr(4'd4, 16'h1);
    modelOn = 0; waitFrames(10); push(3'b100); modelOn = 1;
    regRd(4'd4, v); chk("R7 timeout", 64'(v), 64'h4);
    regWr(4'd4, 16'h4);
    modelOn = 0; waitFrames(30); modelOn = 1;
    regRd(4'd4, v); chk("R7 only once", 64'(v), 64'h0);
    keyEvent(9, 1, 1);
    regWr(4'd4, 16'h1);
    modelOn = 0; waitFrames(10); push(3'b100); modelOn = 1;
    regRd(4'd4, v); chk("R7 restarted", 64'(v), 64'h4);

    // R11 enable clear register
    regWr(4'd6, 16'h7);
    regRd(4'd5, v); chk("R11 enables cleared", 64'(v), 0);
    chk("R11 irq off", 64'(irq), 0);
    regWr(4'd4, 16'h4);

    // R2 scan off
    regWr(4'd0, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R2 rows high when off", 64'(rowDrive), 64'hFF);
    regRd(4'd8, v); chk("R2 map cleared", 64'(v), 0);

    modelOn = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule